// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches a single external interrupt pin and turns activity on it into a latched interrupt flag that stays set until software acknowledges it. A set of configuration inputs switches detection on, chooses between edge-only sensitivity and edge-plus-level sensitivity, picks which pin level counts as active, and gates the flag onto the processor's interrupt request line. While clocks run, the pin passes through a synchronizer before the block looks for edges or levels.

When the device enters a stop state and its clocks are gated, the clocked detector can no longer see the pin. A separate purely combinational path then raises a wake request as soon as the raw pin reaches its active level, provided detection is enabled. That path needs no clock edge. Vector selection and priority among interrupt sources belong to the processor and are not part of this block.

Top module: `xint_pin_detect`

## Requirements
- R1: Synchronous active-high reset clears the flag and the request outputs. A pin that is already at its active level when reset ends is not taken as an edge, so in edge-only mode it sets no flag until it goes inactive and returns.
- R2: While cfg_enable is 0, no pin activity sets the flag, and a flag that was set is cleared on the next clock edge.
- R3: The pin passes through a two-stage synchronizer. When the pin changes between clock edges, the flag shows the change after the third rising edge and not before.
- R4: With cfg_level_mode = 0 (edge-only), only a change of the synchronized pin from inactive to active sets the flag. After an acknowledge, a pin held at the active level does not set it again.
- R5: With cfg_level_mode = 1 (edge-plus-level), an active edge sets the flag. While the synchronized pin stays active, an acknowledge does not clear it.
- R6: cfg_active_high = 1 makes a high level and a rising edge active. cfg_active_high = 0 makes a low level and a falling edge active. Changing cfg_active_high while the pin is steady is not an edge.
- R7: The flag stays set until ack is high at a clock edge, which clears it. A detection on the same edge as ack has priority, so the flag stays set. A new detection after an acknowledge sets the flag again.
- R8: irq_out is high exactly when the flag is set and cfg_irq_enable is 1.
- R9: wake_out is combinational and needs no clock. It is high when stop_mode is 1, cfg_enable is 1, and the raw pin is at the active level. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| stop_mode | input | 1 | High while the device is in its clock-stopped state |
| cfg_enable | input | 1 | Enables detection and the wake path |
| cfg_level_mode | input | 1 | 0 selects edge-only, 1 selects edge-plus-level |
| cfg_active_high | input | 1 | 1 selects high/rising as active, 0 selects low/falling |
| cfg_irq_enable | input | 1 | Gates the flag onto irq_out |
| ack | input | 1 | Flag acknowledge, sampled on the clock edge |
| flag_out | output | 1 | Latched interrupt flag |
| irq_out | output | 1 | Interrupt request to the processor |
| wake_out | output | 1 | Clockless wake request for stop mode |

## Verification
The assertions check the following on every cycle:
- the interrupt gating;
- the clearing of the flag while detection is off;
- that the flag holds until an acknowledge;
- that a synchronized active level in edge-plus-level mode always leaves the flag set;
- that any rising of the flag was preceded by an active synchronized sample;
- that the wake output follows stop state, enable and the raw pin level.

Some behaviours only the bench scenarios show:
- the exact three-edge latency;
- that a level held through an acknowledge is ignored in edge-only mode;
- that a pin already active at reset and a polarity flip on a steady pin are not taken as edges;
- that a detection coinciding with an acknowledge wins.

The bench sweeps both polarities against both sensitivity modes.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int SYNC_STAGES_DEFAULT = 2;

    typedef struct packed {
        logic enable;
        logic level_mode;
        logic active_high;
        logic irq_enable;
    } xint_cfg_t;

    typedef struct packed {
        logic edge_hit;
        logic level_hit;
    } xint_event_t;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2,
        FLAG_OFF   = 2'd3
    } flag_action_e;

    function automatic logic at_active(input logic pin, input logic active_high);
        return pin == active_high;
    endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int STAGES = xint_pkg::SYNC_STAGES_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic pin_sync,
    output logic sync_valid
);
    logic [STAGES-1:0] chain;
    logic [STAGES-1:0] valid;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        chain[0] <= 1'b0;
                        valid[0] <= 1'b0;
                    end else begin
                        chain[0] <= pin_raw;
                        valid[0] <= 1'b1;
                    end
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) begin
                        chain[i] <= 1'b0;
                        valid[i] <= 1'b0;
                    end else begin
                        chain[i] <= chain[i-1];
                        valid[i] <= valid[i-1];
                    end
                end
            end
        end
    endgenerate

    assign pin_sync   = chain[STAGES-1];
    assign sync_valid = valid[STAGES-1];
endmodule

// File: rtl/xint_detect.sv
module xint_detect
    import xint_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_sync,
    input  logic        sync_valid,
    input  xint_cfg_t   cfg,
    output xint_event_t evt
);
    logic prev_pin;
    logic prev_valid;
    logic cur_act;
    logic prev_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pin   <= 1'b0;
            prev_valid <= 1'b0;
        end else begin
            prev_pin   <= pin_sync;
            prev_valid <= sync_valid;
        end
    end

    // Both samples use the current polarity, so a polarity change alone is no edge.
    always_comb begin
        cur_act       = at_active(pin_sync, cfg.active_high);
        prev_act      = at_active(prev_pin, cfg.active_high);
        evt.edge_hit  = cfg.enable && sync_valid && prev_valid && cur_act && !prev_act;
        evt.level_hit = cfg.enable && cfg.level_mode && sync_valid && cur_act;
    end
endmodule

// File: rtl/xint_flag.sv
module xint_flag
    import xint_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  xint_event_t evt,
    input  logic        ack,
    output logic        flag
);
    flag_action_e action;

    always_comb begin
        if (!enable)                          action = FLAG_OFF;
        else if (evt.edge_hit || evt.level_hit) action = FLAG_SET;
        else if (ack)                         action = FLAG_CLEAR;
        else                                  action = FLAG_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            case (action)
                FLAG_SET:   flag <= 1'b1;
                FLAG_CLEAR: flag <= 1'b0;
                FLAG_OFF:   flag <= 1'b0;
                default:    flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/xint_wake.sv
module xint_wake
    import xint_pkg::*;
(
    input  logic      pin_raw,
    input  logic      stop_mode,
    input  xint_cfg_t cfg,
    output logic      wake
);
    always_comb begin
        wake = stop_mode && cfg.enable && at_active(pin_raw, cfg.active_high);
    end
endmodule

// File: rtl/xint_pin_detect.sv
module xint_pin_detect
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic stop_mode,
    input  logic cfg_enable,
    input  logic cfg_level_mode,
    input  logic cfg_active_high,
    input  logic cfg_irq_enable,
    input  logic ack,
    output logic flag_out,
    output logic irq_out,
    output logic wake_out
);
    xint_cfg_t   cfg;
    xint_event_t evt;
    logic        pin_sync;
    logic        sync_valid;

    always_comb begin
        cfg.enable      = cfg_enable;
        cfg.level_mode  = cfg_level_mode;
        cfg.active_high = cfg_active_high;
        cfg.irq_enable  = cfg_irq_enable;
    end

    xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (pin_in),
        .pin_sync   (pin_sync),
        .sync_valid (sync_valid)
    );

    xint_detect u_detect (
        .clk        (clk),
        .rst        (rst),
        .pin_sync   (pin_sync),
        .sync_valid (sync_valid),
        .cfg        (cfg),
        .evt        (evt)
    );

    xint_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg.enable),
        .evt    (evt),
        .ack    (ack),
        .flag   (flag_out)
    );

    xint_wake u_wake (
        .pin_raw   (pin_in),
        .stop_mode (stop_mode),
        .cfg       (cfg),
        .wake      (wake_out)
    );

    assign irq_out = flag_out & cfg.irq_enable;
endmodule

// File: rtl/xint_pin_detect_checks.sv
module xint_pin_detect_checks (
    input logic clk,
    input logic rst,
    input logic pin_in,
    input logic stop_mode,
    input logic cfg_enable,
    input logic cfg_level_mode,
    input logic cfg_active_high,
    input logic cfg_irq_enable,
    input logic ack,
    input logic flag_out,
    input logic irq_out,
    input logic wake_out,
    input logic pin_sync,
    input logic sync_valid
);
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (flag_out && cfg_irq_enable));

    assert_irq_follows_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_out && cfg_irq_enable) |-> irq_out);

    assert_disable_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !flag_out);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_out && !ack && cfg_enable) |=> flag_out);

    assert_level_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && cfg_level_mode && sync_valid && (pin_sync == cfg_active_high)) |=> flag_out);

    assert_rise_after_sync_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_out) |-> $past(sync_valid && (pin_sync == cfg_active_high)));

    assert_wake_qualified_R9: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> (stop_mode && cfg_enable));

    assert_wake_on_level_R9: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && cfg_enable && (pin_in == cfg_active_high)) |-> wake_out);
endmodule

bind xint_pin_detect xint_pin_detect_checks u_checks (
    .clk             (clk),
    .rst             (rst),
    .pin_in          (pin_in),
    .stop_mode       (stop_mode),
    .cfg_enable      (cfg_enable),
    .cfg_level_mode  (cfg_level_mode),
    .cfg_active_high (cfg_active_high),
    .cfg_irq_enable  (cfg_irq_enable),
    .ack             (ack),
    .flag_out        (flag_out),
    .irq_out         (irq_out),
    .wake_out        (wake_out),
    .pin_sync        (pin_sync),
    .sync_valid      (sync_valid)
);

// File: tb/xint_pin_detect_test.sv
`timescale 1ns/1ps
module xint_pin_detect_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_in = 1'b0;
    logic stop_mode = 1'b0;
    logic cfg_enable = 1'b0;
    logic cfg_level_mode = 1'b0;
    logic cfg_active_high = 1'b1;
    logic cfg_irq_enable = 1'b0;
    logic ack = 1'b0;
    logic flag_out, irq_out, wake_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xint_pin_detect uut (
        .clk             (clk),
        .rst             (rst),
        .pin_in          (pin_in),
        .stop_mode       (stop_mode),
        .cfg_enable      (cfg_enable),
        .cfg_level_mode  (cfg_level_mode),
        .cfg_active_high (cfg_active_high),
        .cfg_irq_enable  (cfg_irq_enable),
        .ack             (ack),
        .flag_out        (flag_out),
        .irq_out         (irq_out),
        .wake_out        (wake_out)
    );

    task automatic check(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    initial begin
        // R1: reset state
        tick(3);
        check("R1 flag after reset", flag_out, 1'b0);
        check("R1 irq after reset", irq_out, 1'b0);
        check("R1 wake after reset", wake_out, 1'b0);
        rst = 1'b0;
        tick(2);

        for (int pol = 0; pol < 2; pol++) begin
            for (int mode = 0; mode < 2; mode++) begin
                cfg_enable = 1'b1;
                cfg_level_mode = mode[0];
                cfg_active_high = pol[0];
                cfg_irq_enable = 1'b1;
                pin_in = ~pol[0];
                tick(4);
                pulse_ack();
                check("R6 idle inactive level", flag_out, 1'b0);
                // R3: latency of three edges
                pin_in = pol[0];
                tick(2);
                check("R3 flag not yet after two edges", flag_out, 1'b0);
                tick(1);
                check("R3 R6 flag after third edge", flag_out, 1'b1);
                check("R8 irq with enable", irq_out, 1'b1);
                tick(3);
                check("R7 flag holds without ack", flag_out, 1'b1);
                pulse_ack();
                if (mode == 0) check("R4 held level ignored after ack", flag_out, 1'b0);
                else           check("R5 ack blocked while level active", flag_out, 1'b1);
                tick(3);
                if (mode == 0) check("R4 no re-set from held level", flag_out, 1'b0);
                else           check("R5 flag still set", flag_out, 1'b1);
                pin_in = ~pol[0];
                tick(3);
                pulse_ack();
                check("R7 ack clears flag", flag_out, 1'b0);
                pin_in = pol[0];
                tick(3);
                check("R7 new event sets again", flag_out, 1'b1);
                cfg_irq_enable = 1'b0;
                #1;
                check("R8 irq gated off", irq_out, 1'b0);
                cfg_irq_enable = 1'b1;
                pin_in = ~pol[0];
                tick(3);
                pulse_ack();
                check("R8 irq low after ack", irq_out, 1'b0);
            end
        end

        // R7: detection on the same edge as ack wins (edge-only, active high)
        cfg_level_mode = 1'b0;
        cfg_active_high = 1'b1;
        pin_in = 1'b1;
        tick(3);
        pin_in = 1'b0;
        tick(3);
        check("R7 flag set before collision", flag_out, 1'b1);
        pin_in = 1'b1;
        tick(2);
        pulse_ack();
        check("R7 set wins over ack", flag_out, 1'b1);
        pin_in = 1'b0;
        tick(3);
        pulse_ack();

        // R2: disable clears flag and blocks detection
        pin_in = 1'b1;
        tick(3);
        check("R2 flag set before disable", flag_out, 1'b1);
        cfg_enable = 1'b0;
        tick(1);
        check("R2 disable clears flag", flag_out, 1'b0);
        for (int k = 0; k < 4; k++) begin
            pin_in = ~pin_in;
            tick(3);
            check("R2 no detection while disabled", flag_out, 1'b0);
        end
        cfg_level_mode = 1'b1;
        pin_in = 1'b1;
        tick(3);
        check("R2 level ignored while disabled", flag_out, 1'b0);

        // R6: polarity flip with steady pin is no edge
        cfg_enable = 1'b1;
        cfg_level_mode = 1'b0;
        cfg_active_high = 1'b0;
        pin_in = 1'b1;
        tick(4);
        pulse_ack();
        check("R6 inactive high with low polarity", flag_out, 1'b0);
        cfg_active_high = 1'b1;
        tick(4);
        check("R6 polarity flip not an edge", flag_out, 1'b0);

        // R1: pin active through reset is not an edge
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(6);
        check("R1 active pin at reset not an edge", flag_out, 1'b0);
        pin_in = 1'b0;
        tick(3);
        pin_in = 1'b1;
        tick(3);
        check("R1 later true edge detected", flag_out, 1'b1);
        pulse_ack();

        // R9: clockless wake path
        stop_mode = 1'b1;
        pin_in = 1'b1;
        #1;
        check("R9 wake on active high", wake_out, 1'b1);
        pin_in = 1'b0;
        #1;
        check("R9 wake low on inactive pin", wake_out, 1'b0);
        cfg_active_high = 1'b0;
        #1;
        check("R9 wake on active low", wake_out, 1'b1);
        cfg_enable = 1'b0;
        #1;
        check("R9 wake needs enable", wake_out, 1'b0);
        cfg_enable = 1'b1;
        stop_mode = 1'b0;
        #1;
        check("R9 wake needs stop mode", wake_out, 1'b0);
        tick(2);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule